// File: doc/BRIEF.md
# Processor Bus Address and Strobe Decoder

This block is the glue between an 8-bit processor with a 16-bit address bus and the memories and peripherals on that bus. It divides the address space into three windows: a low RAM window, a small peripheral (I/O) window, and a ROM window that fills the rest of the upper half. For each window it produces an active-low chip select. It also produces active-low write and output enables for the memory devices, and a read/write line for the peripherals. All outputs are combinational functions of the address, the read/write line and the phase-2 clock.

The peripheral window sits at the bottom of the upper half of the map. It is found by comparing the top address bits, from bit 10 upward, against a fixed tag. If the bits equal the tag, the access is to I/O. If they are greater, it is to ROM. If they are less, it is to RAM.

Each output has its own rule for phase 2:
- The memory write strobe is always confined to the phase-2-high half of the cycle.
- Peripheral selects and the peripheral read/write line never depend on phase 2. They are valid as soon as the address settles.
- The memory output enable is gated by phase 2 only when a parameter asks for it.
- The RAM chip select is gated by phase 2 only when a parameter asks for it. The default leaves it ungated for the fastest memory response.

Top module: `glue_bus_decoder`

## Requirements
- R1: Addresses 0x0000 through 0x7FFF assert `ram_cs_n` (low). In the ungated RAM mode this holds in both clock phases. In the gated mode (`RAM_CS_GATED=1`) it holds only while `phi2` is 1.
- R2: Addresses 0x8000 through 0x83FF assert `io_cs_n` (low). Every other address leaves it high.
- R3: Addresses 0x8400 through 0xFFFF assert `rom_cs_n` (low). Every other address leaves it high.
- R4: When `RAM_CS_GATED=0`, exactly one of `ram_cs_n`, `rom_cs_n` and `io_cs_n` is low for every address, read/write value and clock phase.
- R5: `mem_we_n` is low only when `cpu_rw_n` is 0 (write) and `phi2` is 1 together.
- R6: `mem_oe_n` is never low while `cpu_rw_n` is 0.
- R7: With `OE_GATED=0`, `mem_oe_n` equals `cpu_rw_n` inverted, in both phases. With `OE_GATED=1`, it is low only when `cpu_rw_n` is 1 and `phi2` is 1.
- R8: With `RAM_CS_GATED=1`, the following hold:
  - `ram_cs_n` is high whenever `phi2` is 0.
  - `ram_cs_n` is low for RAM addresses while `phi2` is 1.
  - At most one select is low at any time.
- R9: `io_cs_n`, `rom_cs_n` and `periph_rw_n` do not depend on `phi2`. `periph_rw_n` always equals `cpu_rw_n`.
- R10: `mem_oe_n` and `mem_we_n` are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_addr | input | 16 | Processor address bus |
| cpu_rw_n | input | 1 | Processor read/write line: 1 for read, 0 for write |
| phi2 | input | 1 | Phase-2 clock; 1 marks the second half of the bus cycle |
| ram_cs_n | output | 1 | RAM chip select, active low |
| rom_cs_n | output | 1 | ROM chip select, active low |
| io_cs_n | output | 1 | Peripheral window select, active low, never clock-gated |
| mem_we_n | output | 1 | Memory write enable, active low, confined to phase 2 high |
| mem_oe_n | output | 1 | Memory output enable, active low, read cycles only |
| periph_rw_n | output | 1 | Read/write line to peripherals, never clock-gated |

## Verification
The bench builds two copies of the decoder side by side.

The first copy uses the defaults: RAM chip select ungated and output enable ungated. This is the only setting in which exactly one select must be low at every instant. It is also the setting in which the output enable simply follows the read/write line.

The second copy sets both `RAM_CS_GATED` and `OE_GATED` to 1. This brings the phase-1 behaviour of the gated variants within reach:
- the RAM select and the output enable must drop away while `phi2` is 0;
- the peripheral and ROM selects must stay put.

Both copies are swept across every address, with both read/write values and both phases. The boundaries 0x7FFF/0x8000 and 0x83FF/0x8400 therefore fall inside the sweep as well as in the table.

// File: rtl/glue_pkg.sv
package glue_pkg;

  // One-hot region decode before any clock qualification.
  typedef struct packed {
    logic ram;
    logic io;
    logic rom;
  } region_sel_t;

endpackage

// File: rtl/glue_mag_cmp.sv
// Magnitude comparator built as an MSB-first cascade.
// The cascade mirrors a discrete equal/greater comparator chip.
module glue_mag_cmp #(
  parameter int W = 6
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         eq,
  output logic         gt
);

  // Running "still equal" and "already greater" flags, one stage per bit.
  logic [W:0] eq_chain;
  logic [W:0] gt_chain;

  assign eq_chain[W] = 1'b1;
  assign gt_chain[W] = 1'b0;

  for (genvar i = W - 1; i >= 0; i--) begin : g_stage
    assign eq_chain[i] = eq_chain[i+1] & ~(a[i] ^ b[i]);
    assign gt_chain[i] = gt_chain[i+1] | (eq_chain[i+1] & a[i] & ~b[i]);
  end

  assign eq = eq_chain[0];
  assign gt = gt_chain[0];

  always_comb begin
    if (!$isunknown({a, b})) begin
      // R4: equal and greater can never both hold.
      a_r4_cmp_exclusive: assert (!(eq && gt))
        else $error("comparator reports both eq and gt");
    end
  end

endmodule

// File: rtl/glue_map_decode.sv
// Splits the address space into three regions around a tag compare
// on the upper address bits.
module glue_map_decode
  import glue_pkg::*;
#(
  parameter int              AW     = 16,
  parameter int              IO_LSB = 10,
  parameter logic [AW-1:0]   IO_BASE = 16'h8000
) (
  input  logic [AW-1:0] addr,
  output region_sel_t   sel
);

  localparam int TW = AW - IO_LSB;
  localparam logic [TW-1:0] IO_TAG = IO_BASE[AW-1:IO_LSB];

  logic tag_eq;
  logic tag_gt;

  glue_mag_cmp #(.W(TW)) u_cmp (
    .a  (addr[AW-1:IO_LSB]),
    .b  (IO_TAG),
    .eq (tag_eq),
    .gt (tag_gt)
  );

  always_comb begin
    sel.io  = tag_eq;
    sel.rom = tag_gt;
    sel.ram = ~(tag_eq | tag_gt);
  end

  always_comb begin
    if (!$isunknown(addr)) begin
      // R2: the I/O window covers exactly the tag-aligned block.
      a_r2_io_window: assert (sel.io == (addr[AW-1:IO_LSB] == IO_TAG))
        else $error("io decode disagrees with address tag");
      // R4: exactly one region per address.
      a_r4_one_region: assert ($countones(sel) == 1)
        else $error("region decode is not one-hot");
    end
  end

endmodule

// File: rtl/glue_strobe_gate.sv
// Applies the phase-2 qualification rules to selects and strobes.
module glue_strobe_gate
  import glue_pkg::*;
#(
  parameter bit RAM_CS_GATED = 1'b0,
  parameter bit OE_GATED     = 1'b0
) (
  input  region_sel_t sel,
  input  logic        rw_n,
  input  logic        phi2,
  output logic        ram_cs_n,
  output logic        rom_cs_n,
  output logic        io_cs_n,
  output logic        we_n,
  output logic        oe_n,
  output logic        prw_n
);

  // Peripheral-side signals: never qualified by the clock.
  assign io_cs_n  = ~sel.io;
  assign rom_cs_n = ~sel.rom;
  assign prw_n    = rw_n;

  // Write strobe: always confined to the phase-2-high half.
  assign we_n = ~(~rw_n & phi2);

  if (RAM_CS_GATED) begin : g_ram_gated
    assign ram_cs_n = ~(sel.ram & phi2);
  end else begin : g_ram_open
    assign ram_cs_n = ~sel.ram;
  end

  if (OE_GATED) begin : g_oe_gated
    assign oe_n = ~(rw_n & phi2);
  end else begin : g_oe_open
    assign oe_n = ~rw_n;
  end

  always_comb begin
    if (!$isunknown({rw_n, phi2})) begin
      // R10: memory never both driving and being written.
      a_r10_no_contention: assert (!(~oe_n && ~we_n))
        else $error("output enable and write enable both low");
      // R6: output enable only on reads.
      a_r6_oe_read_only: assert (!(~oe_n && ~rw_n))
        else $error("output enable low during write");
      // R5: write strobe needs a write and phase 2 high.
      a_r5_we_qualified: assert (we_n || (~rw_n && phi2))
        else $error("write enable low outside write phase 2");
      // R8: in phase 1 a gated RAM select stays high.
      a_r8_ram_phase1: assert (!RAM_CS_GATED || phi2 || ram_cs_n)
        else $error("gated RAM select low in phase 1");
    end
  end

endmodule

// File: rtl/glue_bus_decoder.sv
module glue_bus_decoder
  import glue_pkg::*;
#(
  parameter int            AW           = 16,
  parameter int            IO_LSB       = 10,
  parameter logic [AW-1:0] IO_BASE      = 16'h8000,
  parameter bit            RAM_CS_GATED = 1'b0,
  parameter bit            OE_GATED     = 1'b0
) (
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_rw_n,
  input  logic          phi2,
  output logic          ram_cs_n,
  output logic          rom_cs_n,
  output logic          io_cs_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic          periph_rw_n
);

  region_sel_t sel;

  glue_map_decode #(
    .AW      (AW),
    .IO_LSB  (IO_LSB),
    .IO_BASE (IO_BASE)
  ) u_map (
    .addr (cpu_addr),
    .sel  (sel)
  );

  glue_strobe_gate #(
    .RAM_CS_GATED (RAM_CS_GATED),
    .OE_GATED     (OE_GATED)
  ) u_gate (
    .sel      (sel),
    .rw_n     (cpu_rw_n),
    .phi2     (phi2),
    .ram_cs_n (ram_cs_n),
    .rom_cs_n (rom_cs_n),
    .io_cs_n  (io_cs_n),
    .we_n     (mem_we_n),
    .oe_n     (mem_oe_n),
    .prw_n    (periph_rw_n)
  );

  always_comb begin
    if (!$isunknown({cpu_addr, cpu_rw_n, phi2})) begin
      // R4 / R8: never two devices selected at once.
      a_r4_select_atmost_one: assert ($countones({~ram_cs_n, ~rom_cs_n, ~io_cs_n}) <= 1)
        else $error("more than one chip select low");
      // R9: peripheral read/write follows the processor line.
      a_r9_periph_rw: assert (periph_rw_n == cpu_rw_n)
        else $error("peripheral rw differs from processor rw");
      // R1: a RAM select never lands above the RAM window.
      a_r1_ram_bound: assert (ram_cs_n || !cpu_addr[AW-1])
        else $error("RAM selected in upper half");
    end
  end

endmodule

// File: tb/glue_bus_decoder_bench.sv
module glue_bus_decoder_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [15:0] addr = 16'h0000;
  logic        rw_n = 1'b1;
  logic        phi2 = 1'b0;

  logic a_ram, a_rom, a_io, a_we, a_oe, a_prw;
  logic b_ram, b_rom, b_io, b_we, b_oe, b_prw;

  glue_bus_decoder u_glue_bus_decoder (
    .cpu_addr (addr), .cpu_rw_n (rw_n), .phi2 (phi2),
    .ram_cs_n (a_ram), .rom_cs_n (a_rom), .io_cs_n (a_io),
    .mem_we_n (a_we), .mem_oe_n (a_oe), .periph_rw_n (a_prw)
  );

  glue_bus_decoder #(.RAM_CS_GATED(1'b1), .OE_GATED(1'b1)) u_glue_bus_decoder_gated (
    .cpu_addr (addr), .cpu_rw_n (rw_n), .phi2 (phi2),
    .ram_cs_n (b_ram), .rom_cs_n (b_rom), .io_cs_n (b_io),
    .mem_we_n (b_we), .mem_oe_n (b_oe), .periph_rw_n (b_prw)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // {addr, rw_n, phi2, ram, rom, io, we, oe, prw} for the default build
  localparam int NV = 12;
  localparam logic [23:0] VEC [NV] = '{
    {16'h0000, 1'b1, 1'b1, 6'b011101},
    {16'h7FFF, 1'b0, 1'b1, 6'b011010},
    {16'h7FFF, 1'b0, 1'b0, 6'b011110},
    {16'h8000, 1'b1, 1'b0, 6'b110101},
    {16'h83FF, 1'b0, 1'b1, 6'b110010},
    {16'h8400, 1'b1, 1'b1, 6'b101101},
    {16'hFFFF, 1'b0, 1'b0, 6'b101110},
    {16'hFFFC, 1'b1, 1'b0, 6'b101101},
    {16'h4000, 1'b0, 1'b1, 6'b011010},
    {16'h83FE, 1'b1, 1'b1, 6'b110101},
    {16'h8401, 1'b0, 1'b1, 6'b101010},
    {16'h0400, 1'b1, 1'b0, 6'b011101}
  };

  task automatic chk(input string tag, input logic got, input logic exp,
                     input logic [15:0] a);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s addr=%h rw_n=%0b phi2=%0b got=%0b exp=%0b",
               tag, a, rw_n, phi2, got, exp);
    end
  endtask

  // Expected outputs from the requirements, per build.
  function automatic logic [5:0] model(input logic [15:0] a, input logic rw,
                                       input logic ph, input bit ram_g,
                                       input bit oe_g);
    logic in_ram, in_io, in_rom;
    logic e_ram, e_oe;
    in_ram = (a <= 16'h7FFF);
    in_io  = (a >= 16'h8000) && (a <= 16'h83FF);
    in_rom = (a >= 16'h8400);
    e_ram  = ram_g ? !(in_ram && ph) : !in_ram;
    e_oe   = oe_g ? !(rw && ph) : !rw;
    return {e_ram, !in_rom, !in_io, !(!rw && ph), e_oe, rw};
  endfunction

  task automatic check_all(input logic [5:0] ea, input logic [5:0] eb);
    chk("R1 ram_cs_n", a_ram, ea[5], addr);
    chk("R3 rom_cs_n", a_rom, ea[4], addr);
    chk("R2 io_cs_n",  a_io,  ea[3], addr);
    chk("R5 mem_we_n", a_we,  ea[2], addr);
    chk("R7 mem_oe_n", a_oe,  ea[1], addr);
    chk("R9 periph_rw_n", a_prw, ea[0], addr);
    chk("R4 one select", 1'(($countones({!a_ram, !a_rom, !a_io}) == 1)), 1'b1, addr);
    chk("R10 oe/we", 1'(!(!a_oe && !a_we)), 1'b1, addr);
    chk("R6 oe on write", 1'(!(!a_oe && !rw_n)), 1'b1, addr);
    chk("R8 ram_cs_n gated", b_ram, eb[5], addr);
    chk("R9 rom_cs_n gated build", b_rom, eb[4], addr);
    chk("R9 io_cs_n gated build",  b_io,  eb[3], addr);
    chk("R5 mem_we_n gated build", b_we,  eb[2], addr);
    chk("R7 mem_oe_n gated", b_oe, eb[1], addr);
    chk("R8 at most one", 1'(($countones({!b_ram, !b_rom, !b_io}) <= 1)), 1'b1, addr);
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    // Reset: idle read at address 0 in phase 1.
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 reset ram_cs_n", a_ram, 1'b0, addr);
    chk("R8 reset gated ram_cs_n", b_ram, 1'b1, addr);
    chk("R7 reset gated oe", b_oe, 1'b1, addr);

    // Vector table, default build.
    for (int i = 0; i < NV; i++) begin
      {addr, rw_n, phi2} = VEC[i][23:6];
      #2;
      check_all(VEC[i][5:0], model(addr, rw_n, phi2, 1'b1, 1'b1));
    end

    // Full sweep: every address, both rw values, both phases.
    for (int a = 0; a < 65536; a++) begin
      for (int m = 0; m < 4; m++) begin
        addr = 16'(a);
        rw_n = m[1];
        phi2 = m[0];
        #1;
        check_all(model(addr, rw_n, phi2, 1'b0, 1'b0),
                  model(addr, rw_n, phi2, 1'b1, 1'b1));
      end
    end

    // Directed: I/O select and peripheral rw hold across a phase-2 edge (R9).
    addr = 16'h8123; rw_n = 1'b0; phi2 = 1'b0; #1;
    chk("R9 io before phi2", b_io, 1'b0, addr);
    phi2 = 1'b1; #1;
    chk("R9 io after phi2", b_io, 1'b0, addr);
    chk("R9 prw after phi2", b_prw, 1'b0, addr);
    chk("R5 write strobe in phase 2", b_we, 1'b0, addr);
    phi2 = 1'b0; #1;
    chk("R5 write strobe released", b_we, 1'b1, addr);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule